// File: doc/BRIEF.md
# Circular Load/Store Queue Controller

This block keeps the bookkeeping for two circular queues inside an out-of-order core's memory stage: one ring for loads and one for stores. Each ring holds a configurable number of entries plus one spare slot that is never filled, so the tail slot is always empty and a full ring can be told apart from an empty one. Loads and stores enter in program order, each tagged with a sequence number, through valid/ready allocation ports. A commit request retires every older instruction: loads leave the ring at once, while stores only become eligible to write to memory and stay resident until the memory side acknowledges their write.

A third pointer in the store ring walks ahead of the store head and offers the next eligible store on a valid/ready writeback port. A squash request trims every entry younger than a given sequence number from the tails of both rings. A small tracker records the oldest load that the cache refused and raises a sticky blocked flag until software-independent pipeline control clears it. Occupancy, per-ring full, overall full, a free-entry count and the sequence numbers at both heads are reported as plain status pins.

Back-pressure: an allocation is taken only on a cycle where its valid and ready are both high; ready drops while the ring is full or a squash is being applied. A writeback is taken when wb_valid and wb_ready are both high; while wb_ready is low the offered store and its sequence number hold steady.

Top module: `lsq_ring_ctrl`

## Requirements
- R1: The load ring accepts at most LQ_N loads and the store ring at most SQ_N stores; lq_full (sq_full) is high exactly when the ring holds that many, and the matching ready output is low while full, so an offered entry is dropped from the count.
- R2: any_full is the OR of lq_full and sq_full, and free_cnt equals the smaller of (LQ_N - lq_count) and (SQ_N - sq_count).
- R3: An entry is accepted on a clock edge where its valid and ready are high; the ring's count rises by one after that edge, and after reset both counts are zero.
- R4: On commit_valid, every resident load whose sequence number is below commit_seq is released at that edge.
- R5: On commit_valid, every resident store whose sequence number is below commit_seq is marked committed and allowed to write back, but stays resident and keeps counting in sq_count.
- R6: wb_valid is high when the store at the writeback pointer is committed, allowed to write back and not yet completed, with its sequence number on wb_seq; on wb_valid and wb_ready the store is marked completed and the pointer moves to the next store; while wb_ready is low, wb_valid and wb_seq hold.
- R7: wb_ack releases the oldest store only when that store is completed; an acknowledge at any other time has no effect on sq_count or sq_head_seq.
- R8: On squash_valid, every resident load and store whose sequence number is greater than squash_seq is removed from the ring tails, and no allocation is accepted in that cycle.
- R9: A pulse on ld_refuse sets blocked and records ld_refuse_seq in blocked_seq, unless a blocked load with a smaller sequence number is already recorded, in which case the record is kept.
- R10: blocked stays high until blk_clear; when blk_clear and ld_refuse arrive together, the clear takes effect first and the new refusal is recorded.
- R11: lq_head_seq and sq_head_seq give the sequence number of the oldest resident entry, and read zero when their ring is empty.
- R12: Head, tail and writeback pointers wrap around the ring's slot count (entries plus one), so arbitrarily long runs of traffic keep the ring behaviour above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load allocation request |
| ld_ready | output | 1 | Load ring can take an entry this cycle |
| ld_seq | input | SEQ_W | Sequence number of the offered load |
| st_valid | input | 1 | Store allocation request |
| st_ready | output | 1 | Store ring can take an entry this cycle |
| st_seq | input | SEQ_W | Sequence number of the offered store |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Entries below this number commit |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries above this number are removed |
| wb_valid | output | 1 | A store is offered for writeback |
| wb_ready | input | 1 | Store port not blocked, takes the offer |
| wb_seq | output | SEQ_W | Sequence number of the offered store |
| wb_ack | input | 1 | Memory write of the oldest store finished |
| ld_refuse | input | 1 | Cache refused a load this cycle |
| ld_refuse_seq | input | SEQ_W | Sequence number of the refused load |
| blk_clear | input | 1 | Clears the blocked flag |
| blocked | output | 1 | A refused load is recorded |
| blocked_seq | output | SEQ_W | Sequence number of the recorded load |
| lq_count | output | $clog2(LQ_N+1) | Loads resident |
| sq_count | output | $clog2(SQ_N+1) | Stores resident |
| lq_full | output | 1 | Load ring full |
| sq_full | output | 1 | Store ring full |
| any_full | output | 1 | Either ring full |
| free_cnt | output | max of the two count widths | Entries free in both rings |
| lq_head_seq | output | SEQ_W | Oldest load's number, zero if empty |
| sq_head_seq | output | SEQ_W | Oldest store's number, zero if empty |

## Verification
The bench builds the block with LQ_N = 4 and SQ_N = 3, so the two rings have five and four slots: one wraps at a non-power-of-two and one at a power of two, and the unequal depths let free_cnt switch between being limited by either ring. The small depths make both full conditions, allocation refusal and many pointer wraps occur within a few thousand cycles of mixed traffic, alongside directed runs of commit, squash, writeback stalls, stray acknowledges and the refused-load ordering.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  // Status bits kept for every store slot.
  typedef struct packed {
    logic wb_ok;   // allowed to write back
    logic cmt;     // committed
    logic done;    // write issued to memory
  } st_flag_t;

  // Advance a ring index by k positions, modulo the slot count.
  function automatic int ring_step(int p, int k, int slots);
    int s;
    s = p + k;
    if (s >= slots) s = s - slots;
    return s;
  endfunction

endpackage

// File: rtl/lsq_lq_ring.sv
module lsq_lq_ring #(
  parameter int N = 4,
  parameter int SEQ_W = 16,
  localparam int SLOTS = N + 1,
  localparam int PW = $clog2(SLOTS),
  localparam int CW = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic             commit_v,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             squash_v,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic [CW-1:0]    count,
  output logic [SEQ_W-1:0] head_seq
);
  import lsq_pkg::*;

  logic [SLOTS-1:0] vld_q;
  logic [SEQ_W-1:0] seq_q [SLOTS];
  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;
  logic [SLOTS-1:0] pop_m, kill_m;
  logic [CW-1:0]    pop_n, kill_n;

  always_comb begin
    pop_n  = '0;
    kill_n = '0;
    for (int i = 0; i < SLOTS; i++) begin
      pop_m[i]  = commit_v && vld_q[i] && (seq_q[i] < commit_seq);
      kill_m[i] = squash_v && vld_q[i] && (seq_q[i] > squash_seq);
      pop_n     = pop_n + CW'(pop_m[i]);
      kill_n    = kill_n + CW'(kill_m[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < SLOTS; i++) seq_q[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (pop_m[i] || kill_m[i]) vld_q[i] <= 1'b0;
        if (push && tail_q == PW'(i)) begin
          vld_q[i] <= 1'b1;
          seq_q[i] <= push_seq;
        end
      end
      head_q <= PW'(ring_step(int'(head_q), int'(pop_n), SLOTS));
      if (squash_v)
        tail_q <= PW'(ring_step(int'(tail_q), SLOTS - int'(kill_n), SLOTS));
      else if (push)
        tail_q <= PW'(ring_step(int'(tail_q), 1, SLOTS));
      cnt_q <= cnt_q + CW'(push) - pop_n - kill_n;
    end
  end

  assign count    = cnt_q;
  assign head_seq = vld_q[head_q] ? seq_q[head_q] : '0;

endmodule

// File: rtl/lsq_sq_ring.sv
module lsq_sq_ring #(
  parameter int N = 4,
  parameter int SEQ_W = 16,
  localparam int SLOTS = N + 1,
  localparam int PW = $clog2(SLOTS),
  localparam int CW = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic             commit_v,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             squash_v,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [SEQ_W-1:0] wb_seq,
  input  logic             wb_ack,
  output logic [CW-1:0]    count,
  output logic [SEQ_W-1:0] head_seq
);
  import lsq_pkg::*;

  logic [SLOTS-1:0] vld_q;
  logic [SEQ_W-1:0] seq_q [SLOTS];
  st_flag_t         flg_q [SLOTS];
  logic [PW-1:0]    head_q, tail_q, wbp_q;
  logic [CW-1:0]    cnt_q;
  logic [SLOTS-1:0] cmt_m, kill_m;
  logic [CW-1:0]    kill_n;
  logic             wb_fire, ack_pop;

  always_comb begin
    kill_n = '0;
    for (int i = 0; i < SLOTS; i++) begin
      cmt_m[i]  = commit_v && vld_q[i] && (seq_q[i] < commit_seq);
      kill_m[i] = squash_v && vld_q[i] && (seq_q[i] > squash_seq);
      kill_n    = kill_n + CW'(kill_m[i]);
    end
  end

  // Offer the store at the writeback pointer once it may go and has not gone.
  assign wb_valid = vld_q[wbp_q] && flg_q[wbp_q].wb_ok && flg_q[wbp_q].cmt
                    && !flg_q[wbp_q].done;
  assign wb_seq   = seq_q[wbp_q];
  assign wb_fire  = wb_valid && wb_ready;
  assign ack_pop  = wb_ack && vld_q[head_q] && flg_q[head_q].done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      wbp_q  <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        seq_q[i] <= '0;
        flg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (cmt_m[i]) begin
          flg_q[i].cmt   <= 1'b1;
          flg_q[i].wb_ok <= 1'b1;
        end
        if (wb_fire && wbp_q == PW'(i)) flg_q[i].done <= 1'b1;
        if (kill_m[i]) vld_q[i] <= 1'b0;
        if (ack_pop && head_q == PW'(i)) vld_q[i] <= 1'b0;
        if (push && tail_q == PW'(i)) begin
          vld_q[i] <= 1'b1;
          seq_q[i] <= push_seq;
          flg_q[i] <= '0;
        end
      end
      if (ack_pop) head_q <= PW'(ring_step(int'(head_q), 1, SLOTS));
      if (wb_fire) wbp_q <= PW'(ring_step(int'(wbp_q), 1, SLOTS));
      if (squash_v)
        tail_q <= PW'(ring_step(int'(tail_q), SLOTS - int'(kill_n), SLOTS));
      else if (push)
        tail_q <= PW'(ring_step(int'(tail_q), 1, SLOTS));
      cnt_q <= cnt_q + CW'(push) - CW'(ack_pop) - kill_n;
    end
  end

  assign count    = cnt_q;
  assign head_seq = vld_q[head_q] ? seq_q[head_q] : '0;

endmodule

// File: rtl/lsq_blk_track.sv
module lsq_blk_track #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refuse,
  input  logic [SEQ_W-1:0] refuse_seq,
  input  logic             clear,
  output logic             blocked,
  output logic [SEQ_W-1:0] blocked_seq
);
  logic             blk_q;
  logic [SEQ_W-1:0] bseq_q;
  logic             still_blk;

  // A clear in the same cycle is applied before the refusal is weighed.
  assign still_blk = blk_q && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= 1'b0;
      bseq_q <= '0;
    end else if (refuse && (!still_blk || refuse_seq < bseq_q)) begin
      blk_q  <= 1'b1;
      bseq_q <= refuse_seq;
    end else if (clear) begin
      blk_q <= 1'b0;
    end
  end

  assign blocked     = blk_q;
  assign blocked_seq = bseq_q;

endmodule

// File: rtl/lsq_ring_ctrl.sv
module lsq_ring_ctrl #(
  parameter int LQ_N = 4,
  parameter int SQ_N = 4,
  parameter int SEQ_W = 16,
  localparam int LCW = $clog2(LQ_N + 1),
  localparam int SCW = $clog2(SQ_N + 1),
  localparam int FCW = (LCW > SCW) ? LCW : SCW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [SEQ_W-1:0] ld_seq,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [SEQ_W-1:0] st_seq,
  input  logic             commit_valid,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [SEQ_W-1:0] wb_seq,
  input  logic             wb_ack,
  input  logic             ld_refuse,
  input  logic [SEQ_W-1:0] ld_refuse_seq,
  input  logic             blk_clear,
  output logic             blocked,
  output logic [SEQ_W-1:0] blocked_seq,
  output logic [LCW-1:0]   lq_count,
  output logic [SCW-1:0]   sq_count,
  output logic             lq_full,
  output logic             sq_full,
  output logic             any_full,
  output logic [FCW-1:0]   free_cnt,
  output logic [SEQ_W-1:0] lq_head_seq,
  output logic [SEQ_W-1:0] sq_head_seq
);
  logic ld_push, st_push;
  int   lq_free, sq_free;

  assign lq_full  = int'(lq_count) >= LQ_N;
  assign sq_full  = int'(sq_count) >= SQ_N;
  assign any_full = lq_full || sq_full;
  assign ld_ready = !lq_full && !squash_valid;
  assign st_ready = !sq_full && !squash_valid;
  assign ld_push  = ld_valid && ld_ready;
  assign st_push  = st_valid && st_ready;

  always_comb begin
    lq_free  = LQ_N - int'(lq_count);
    sq_free  = SQ_N - int'(sq_count);
    free_cnt = FCW'((lq_free < sq_free) ? lq_free : sq_free);
  end

  lsq_lq_ring #(.N(LQ_N), .SEQ_W(SEQ_W)) u_lq (
    .clk(clk), .rst_n(rst_n), .push(ld_push), .push_seq(ld_seq),
    .commit_v(commit_valid), .commit_seq(commit_seq),
    .squash_v(squash_valid), .squash_seq(squash_seq),
    .count(lq_count), .head_seq(lq_head_seq)
  );

  lsq_sq_ring #(.N(SQ_N), .SEQ_W(SEQ_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .push(st_push), .push_seq(st_seq),
    .commit_v(commit_valid), .commit_seq(commit_seq),
    .squash_v(squash_valid), .squash_seq(squash_seq),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_seq(wb_seq),
    .wb_ack(wb_ack), .count(sq_count), .head_seq(sq_head_seq)
  );

  lsq_blk_track #(.SEQ_W(SEQ_W)) u_blk (
    .clk(clk), .rst_n(rst_n), .refuse(ld_refuse), .refuse_seq(ld_refuse_seq),
    .clear(blk_clear), .blocked(blocked), .blocked_seq(blocked_seq)
  );

endmodule

// File: rtl/lsq_ring_chk.sv
module lsq_ring_chk #(
  parameter int LQ_N = 4,
  parameter int SQ_N = 4,
  parameter int SEQ_W = 16,
  localparam int LCW = $clog2(LQ_N + 1),
  localparam int SCW = $clog2(SQ_N + 1),
  localparam int FCW = (LCW > SCW) ? LCW : SCW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             squash_valid,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [SEQ_W-1:0] wb_seq,
  input logic             wb_ack,
  input logic             st_valid,
  input logic             ld_refuse,
  input logic             blk_clear,
  input logic             blocked,
  input logic [SEQ_W-1:0] blocked_seq,
  input logic [LCW-1:0]   lq_count,
  input logic [SCW-1:0]   sq_count,
  input logic             lq_full,
  input logic [FCW-1:0]   free_cnt,
  input logic [SEQ_W-1:0] lq_head_seq,
  input logic [SEQ_W-1:0] sq_head_seq
);

  a_r1_lq_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lq_count) <= LQ_N);

  a_r1_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    lq_full |=> lq_count <= $past(lq_count));

  a_r2_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(free_cnt) <= LQ_N - int'(lq_count)) && (int'(free_cnt) <= SQ_N - int'(sq_count)));

  a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready && !squash_valid |=> wb_valid && $stable(wb_seq));

  a_r7_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack && !st_valid && !wb_valid && sq_count == '0 |=> sq_count == '0);

  a_r8_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (lq_count <= $past(lq_count)) && (sq_count <= $past(sq_count)));

  a_r9_keep_older: assert property (@(posedge clk) disable iff (!rst_n)
    blocked && ld_refuse && !blk_clear |=> blocked && (blocked_seq <= $past(blocked_seq)));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    blocked && !blk_clear && !ld_refuse |=> blocked && $stable(blocked_seq));

  a_r11_empty_heads: assert property (@(posedge clk) disable iff (!rst_n)
    ((lq_count == '0) -> (lq_head_seq == '0)) && ((sq_count == '0) -> (sq_head_seq == '0)));

endmodule

bind lsq_ring_ctrl lsq_ring_chk #(.LQ_N(LQ_N), .SQ_N(SQ_N), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .squash_valid(squash_valid),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_seq(wb_seq), .wb_ack(wb_ack),
  .st_valid(st_valid), .ld_refuse(ld_refuse), .blk_clear(blk_clear),
  .blocked(blocked), .blocked_seq(blocked_seq),
  .lq_count(lq_count), .sq_count(sq_count), .lq_full(lq_full),
  .free_cnt(free_cnt), .lq_head_seq(lq_head_seq), .sq_head_seq(sq_head_seq)
);

// File: tb/tb_lsq_ring_ctrl.sv
`timescale 1ns/100ps
module tb_lsq_ring_ctrl;
  localparam int LQ_N = 4;
  localparam int SQ_N = 3;
  localparam int SEQ_W = 16;
  localparam int LCW = $clog2(LQ_N + 1);
  localparam int SCW = $clog2(SQ_N + 1);
  localparam int FCW = (LCW > SCW) ? LCW : SCW;

  logic clk = 1'b0;
  logic rst_n;
  logic ld_valid, st_valid, commit_valid, squash_valid, wb_ready, wb_ack;
  logic ld_refuse, blk_clear;
  logic [SEQ_W-1:0] ld_seq, st_seq, commit_seq, squash_seq, ld_refuse_seq;
  logic ld_ready, st_ready, wb_valid, blocked, lq_full, sq_full, any_full;
  logic [SEQ_W-1:0] wb_seq, blocked_seq, lq_head_seq, sq_head_seq;
  logic [LCW-1:0] lq_count;
  logic [SCW-1:0] sq_count;
  logic [FCW-1:0] free_cnt;

  always #2.5 clk = ~clk;

  lsq_ring_ctrl #(.LQ_N(LQ_N), .SQ_N(SQ_N), .SEQ_W(SEQ_W)) dut (.*);

  // Reference model: plain queues of sequence numbers and store status.
  int lq[$];
  int sq_seq[$];
  bit sq_c[$];
  bit sq_d[$];
  int wbi;
  bit m_blk;
  int m_bseq;
  bit e_ldr, e_str, e_wbv;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  string ptag = "R3";

  function automatic void cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endfunction

  task automatic idle();
    ld_valid = 0; st_valid = 0; commit_valid = 0; squash_valid = 0;
    wb_ready = 0; wb_ack = 0; ld_refuse = 0; blk_clear = 0;
    ld_seq = '0; st_seq = '0; commit_seq = '0; squash_seq = '0; ld_refuse_seq = '0;
  endtask

  task automatic compare_all();
    int lc, sc, lf, sf;
    lc = lq.size(); sc = sq_seq.size();
    lf = LQ_N - lc; sf = SQ_N - sc;
    e_ldr = (lc < LQ_N) && !squash_valid;
    e_str = (sc < SQ_N) && !squash_valid;
    e_wbv = (wbi < sc) && sq_c[wbi] && !sq_d[wbi];
    cmp({ptag, " lq_count"}, int'(lq_count), lc);
    cmp({ptag, " sq_count"}, int'(sq_count), sc);
    cmp("R1 lq_full", int'(lq_full), int'(lc >= LQ_N));
    cmp("R1 sq_full", int'(sq_full), int'(sc >= SQ_N));
    cmp("R1 ld_ready", int'(ld_ready), int'(e_ldr));
    cmp("R1 st_ready", int'(st_ready), int'(e_str));
    cmp("R2 any_full", int'(any_full), int'(lc >= LQ_N || sc >= SQ_N));
    cmp("R2 free_cnt", int'(free_cnt), (lf < sf) ? lf : sf);
    cmp("R11 lq_head_seq", int'(lq_head_seq), lc > 0 ? lq[0] : 0);
    cmp("R11 sq_head_seq", int'(sq_head_seq), sc > 0 ? sq_seq[0] : 0);
    cmp("R6 wb_valid", int'(wb_valid), int'(e_wbv));
    if (e_wbv) cmp("R6 wb_seq", int'(wb_seq), sq_seq[wbi]);
    cmp("R9 blocked", int'(blocked), int'(m_blk));
    if (m_blk) cmp("R10 blocked_seq", int'(blocked_seq), m_bseq);
  endtask

  task automatic model_update();
    bit lf, sf, wf, ak, still;
    lf = ld_valid && e_ldr;
    sf = st_valid && e_str;
    wf = e_wbv && wb_ready;
    ak = wb_ack && sq_seq.size() > 0 && sq_d[0];
    if (wf) begin sq_d[wbi] = 1; wbi++; end
    if (commit_valid) begin
      while (lq.size() > 0 && lq[0] < int'(commit_seq)) void'(lq.pop_front());
      foreach (sq_seq[i]) if (sq_seq[i] < int'(commit_seq)) sq_c[i] = 1;
    end
    if (ak) begin
      void'(sq_seq.pop_front()); void'(sq_c.pop_front()); void'(sq_d.pop_front());
      wbi--;
    end
    if (squash_valid) begin
      while (lq.size() > 0 && lq[$] > int'(squash_seq)) void'(lq.pop_back());
      while (sq_seq.size() > 0 && sq_seq[$] > int'(squash_seq)) begin
        void'(sq_seq.pop_back()); void'(sq_c.pop_back()); void'(sq_d.pop_back());
      end
      if (wbi > sq_seq.size()) wbi = sq_seq.size();
    end
    if (lf) lq.push_back(int'(ld_seq));
    if (sf) begin sq_seq.push_back(int'(st_seq)); sq_c.push_back(0); sq_d.push_back(0); end
    still = m_blk && !blk_clear;
    if (ld_refuse && (!still || int'(ld_refuse_seq) < m_bseq)) begin
      m_blk = 1; m_bseq = int'(ld_refuse_seq);
    end else if (blk_clear) m_blk = 0;
  endtask

  task automatic tick();
    #1;
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    int nseq, chi;
    idle();
    rst_n = 0;
    wbi = 0; m_blk = 0; m_bseq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state
    #1;
    cmp("R3 reset lq_count", int'(lq_count), 0);
    cmp("R11 reset lq_head_seq", int'(lq_head_seq), 0);
    cmp("R11 reset sq_head_seq", int'(sq_head_seq), 0);
    @(negedge clk);
    tick();

    // Fill the load ring; the fifth load must be refused.
    for (int k = 0; k < 5; k++) begin
      idle(); ld_valid = 1; ld_seq = SEQ_W'(10 + k); tick();
    end
    cmp("R1 lq holds LQ_N", int'(lq_count), LQ_N);
    // Fill the store ring; the fourth store must be refused.
    for (int k = 0; k < 4; k++) begin
      idle(); st_valid = 1; st_seq = SEQ_W'(20 + k); tick();
    end
    cmp("R1 sq holds SQ_N", int'(sq_count), SQ_N);
    cmp("R2 free_cnt zero when full", int'(free_cnt), 0);

    // Commit below 12: loads 10 and 11 leave, no store is touched.
    idle(); commit_valid = 1; commit_seq = 16'd12; tick();
    cmp("R4 loads released", int'(lq_count), 2);
    cmp("R4 new load head", int'(lq_head_seq), 12);
    cmp("R5 stores stay", int'(sq_count), 3);
    cmp("R2 free limited by store ring", int'(free_cnt), 0);
    // Commit below 22: loads gone, stores 20 and 21 eligible.
    idle(); commit_valid = 1; commit_seq = 16'd22; tick();
    cmp("R4 all loads released", int'(lq_count), 0);
    cmp("R5 committed stores resident", int'(sq_count), 3);
    cmp("R6 first offer", int'(wb_seq), 20);
    // Stall the writeback port.
    idle(); tick(); idle(); tick();
    cmp("R6 offer held under stall", int'(wb_valid), 1);
    cmp("R6 seq held under stall", int'(wb_seq), 20);
    // Acknowledge with nothing completed: ignored.
    idle(); wb_ack = 1; tick();
    cmp("R7 stray ack count", int'(sq_count), 3);
    cmp("R7 stray ack head", int'(sq_head_seq), 20);
    // Issue store 20, then acknowledge it.
    idle(); wb_ready = 1; tick();
    cmp("R6 pointer advanced", int'(wb_seq), 21);
    idle(); wb_ack = 1; tick();
    cmp("R7 ack frees oldest", int'(sq_count), 2);
    cmp("R7 head after ack", int'(sq_head_seq), 21);

    // Squash: loads 30..32 and store 33, then drop everything above 30.
    for (int k = 0; k < 3; k++) begin
      idle(); ld_valid = 1; ld_seq = SEQ_W'(30 + k); tick();
    end
    idle(); st_valid = 1; st_seq = 16'd33; tick();
    idle(); squash_valid = 1; squash_seq = 16'd30; ld_valid = 1; ld_seq = 16'd40; tick();
    cmp("R8 loads trimmed", int'(lq_count), 1);
    cmp("R8 stores trimmed", int'(sq_count), 2);
    cmp("R8 no alloc during squash", int'(lq_head_seq), 30);

    // Refused loads.
    idle(); ld_refuse = 1; ld_refuse_seq = 16'd200; tick();
    cmp("R9 first refusal", int'(blocked_seq), 200);
    idle(); ld_refuse = 1; ld_refuse_seq = 16'd250; tick();
    cmp("R9 younger refusal ignored", int'(blocked_seq), 200);
    idle(); ld_refuse = 1; ld_refuse_seq = 16'd150; tick();
    cmp("R9 older refusal recorded", int'(blocked_seq), 150);
    idle(); tick();
    cmp("R10 flag sticky", int'(blocked), 1);
    idle(); blk_clear = 1; tick();
    cmp("R10 cleared", int'(blocked), 0);
    idle(); ld_refuse = 1; ld_refuse_seq = 16'd170; tick();
    idle(); blk_clear = 1; ld_refuse = 1; ld_refuse_seq = 16'd300; tick();
    cmp("R10 clear then record", int'(blocked_seq), 300);
    cmp("R10 flag after clear+refuse", int'(blocked), 1);

    // Mixed random traffic for many wraps.
    ptag = "R12";
    nseq = 400; chi = 22;
    for (int k = 0; k < 4000; k++) begin
      int r;
      idle();
      ld_valid = ($urandom % 2) == 0; ld_seq = SEQ_W'(nseq);
      st_valid = ($urandom % 3) == 0; st_seq = SEQ_W'(nseq + 1);
      r = $urandom % 100;
      if (r < 15) begin
        int c;
        c = nseq - int'($urandom % 6);
        commit_valid = 1; commit_seq = SEQ_W'(c);
        if (c > chi) chi = c;
      end else if (r < 20) begin
        squash_valid = 1; squash_seq = SEQ_W'(chi + int'($urandom % 4));
      end
      wb_ready = ($urandom % 10) < 7;
      wb_ack = (sq_d.size() > 0 && sq_d[0]) ? (($urandom % 2) == 0) : (($urandom % 20) == 0);
      ld_refuse = ($urandom % 25) == 0; ld_refuse_seq = SEQ_W'($urandom % 60000);
      blk_clear = ($urandom % 30) == 0;
      tick();
      nseq += 2;
    end
    idle(); tick();
    finish_run();
  end

endmodule